// File: doc/BRIEF.md
# Chainable Serial Configuration Register Slave

This block is a serial slave that exposes a small bank of 8-bit configuration registers through 16-bit frames. A host lowers the active-low select, clocks sixteen bits in on the data input and raises the select again. Each frame carries a direction flag, a 7-bit register address and a data byte. While a frame shifts in, the frame received in the previous select window shifts out on the serial output. Several slaves can therefore be chained, each one's serial output feeding the next one's serial input, with all of them sharing the serial clock and the select.

A write takes effect when the select rises at the end of a well-formed frame. A read takes two select windows. The first window carries the read command. When it closes, the slave places the register value in the low byte of its shift stage, so the value comes out at the end of the second window. Frames that do not carry exactly sixteen clock pulses are discarded.

The serial pins are sampled by a fast system clock through synchronizers, and serial clock edges are found by edge detection. The pad tri-state is represented by an output-enable signal. The register contents are exported in parallel to drive the logic they configure.

Top module: `spi_chain_slave`

## Requirements
- R1: A frame is 16 bits sent MSB first: bit 15 is the direction (1 = read, 0 = write), bits 14..8 the register address, bits 7..0 the data byte.
- R2: During each select window the serial output presents, MSB first, the 16 bits held in the shift stage when the window opened, which is the previous frame (after any read load). The first bit is valid before the first serial-clock rise.
- R3: The output enable is high only while the synchronized select is low. It follows the select input two system clocks later.
- R4: A write frame with exactly 16 clock rises updates the addressed register when the select rises. The new value appears on the parallel configuration output.
- R5: After a read frame with exactly 16 rises, the next window returns bit 15 = 1, the address in bits 14..8 and the register value in bits 7..0. The padding byte of the read frame is ignored.
- R6: A frame with any number of clock rises other than 16 causes neither a register write nor a read load. Its bits still pass through the shift stage.
- R7: Reserved register bits keep their reset value and ignore writes. Addresses at or above the register count read as 0x00. The default map is: reg0 reset 0x00 with all bits writable; reg1 reset 0x5A with all bits writable; reg2 reset 0x80 with bits 3..0 writable; reg3 reset 0x03 with bits 7..4, 1 and 0 writable.
- R8: After reset the registers hold their reset values, the output enable is low and the shift stage is zero, so the first frame's output is all zeros.
- R9: The serial output changes only after a serial-clock fall or a select fall, never because of a serial-clock rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| ss_n_i | input | 1 | Active-low frame select |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out (valid while the enable is high) |
| miso_oe_o | output | 1 | Output enable for the serial data pad |
| cfg_o | output | NUM_REGS*8 | Register contents; register i occupies bits 8*i+7..8*i |

## Verification
The embedded assertions check several properties on every cycle. The output enable must track the select after two synchronizer stages. The serial output must hold still across serial-clock rises. A write pulse must be single and may only follow a full-length frame. Reserved bits must never leave their reset value. Other behaviours can only be shown by the bench's directed frames, because they span whole transactions. These are the frame-to-frame echo, the one-frame-late read data, the decoding of address and data positions, the read value of unmapped addresses and the discarding of frames that are too short or too long.

// File: rtl/spi_chain_pkg.sv
// Package: shared constants, frame layout and default register map for the
// chainable serial register slave. Assumes a fixed 16-bit frame.
package spi_chain_pkg;

    localparam int FRAME_BITS  = 16;
    localparam int ADDR_W      = 7;
    localparam int DATA_W      = 8;
    localparam int CNT_W       = 5;   // counts rises, saturates at 31
    localparam int SYNC_STAGES = 2;   // metastability stages on each pin

    // Decoded view of one frame held in the shift stage
    typedef struct packed {
        logic              is_read;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    // Reset value of register idx; unmapped indices give zero
    function automatic logic [DATA_W-1:0] reg_reset_val(input int idx);
        case (idx)
            0:       return 8'h00;
            1:       return 8'h5A;
            2:       return 8'h80;
            3:       return 8'h03;
            default: return 8'h00;
        endcase
    endfunction

    // Writable-bit mask of register idx; zero bits are reserved
    function automatic logic [DATA_W-1:0] reg_wr_mask(input int idx);
        case (idx)
            0:       return 8'hFF;
            1:       return 8'hFF;
            2:       return 8'h0F;
            3:       return 8'hF3;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
// Module: spi_pin_sync
// Brings the asynchronous serial pins into the system clock domain and
// produces single-cycle edge strobes for the serial clock and the select.
// Assumes the system clock is at least four times faster than the serial clock.
module spi_pin_sync
    import spi_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic ss_n_i,
    input  logic mosi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic ss_fall,
    output logic ss_rise,
    output logic ss_active,
    output logic mosi_s
);

    localparam int HIST = SYNC_STAGES + 1;

    logic [HIST-1:0]        sck_pipe;
    logic [HIST-1:0]        ss_pipe;
    logic [SYNC_STAGES-1:0] mosi_pipe;

    // Synchronizer chains with one extra history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_pipe  <= '0;
            ss_pipe   <= '1;
            mosi_pipe <= '0;
        end else begin
            sck_pipe  <= {sck_pipe[HIST-2:0], sck_i};
            ss_pipe   <= {ss_pipe[HIST-2:0], ss_n_i};
            mosi_pipe <= {mosi_pipe[SYNC_STAGES-2:0], mosi_i};
        end
    end

    // Edge strobes compare the synchronized stage against its history
    always_comb begin
        sck_rise  =  sck_pipe[SYNC_STAGES-1] & ~sck_pipe[HIST-1];
        sck_fall  = ~sck_pipe[SYNC_STAGES-1] &  sck_pipe[HIST-1];
        ss_fall   = ~ss_pipe[SYNC_STAGES-1]  &  ss_pipe[HIST-1];
        ss_rise   =  ss_pipe[SYNC_STAGES-1]  & ~ss_pipe[HIST-1];
        ss_active = ~ss_pipe[SYNC_STAGES-1];
        mosi_s    =  mosi_pipe[SYNC_STAGES-1];
    end

endmodule

// File: rtl/spi_frame_shifter.sv
// Module: spi_frame_shifter
// 16-bit shift stage with rise counter. Shifts data in on serial-clock rises,
// drives the output bit on select fall and serial-clock falls, and at select
// rise either issues a register write or loads read data into the low byte.
// Assumes edge strobes are single-cycle pulses in the system clock domain.
module spi_frame_shifter
    import spi_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              ss_fall,
    input  logic              ss_rise,
    input  logic              ss_active,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              miso_q,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    frame_t           shift_q;
    logic [CNT_W-1:0] bit_cnt;
    logic             frame_ok;
    logic             do_load;
    logic             do_write;

    always_comb begin
        frame_ok = (bit_cnt == CNT_FULL);
        do_load  = ss_rise & frame_ok &  shift_q.is_read;
        do_write = ss_rise & frame_ok & ~shift_q.is_read;
        rd_addr  = shift_q.addr;
    end

    // Shift stage: read-data load at frame close, otherwise shift on rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (do_load) begin
            shift_q.data <= rd_data;
        end else if (sck_rise && ss_active) begin
            shift_q <= {shift_q[FRAME_BITS-2:0], mosi_s};
        end
    end

    // Rise counter: cleared at select fall, saturating during the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (ss_fall) begin
            bit_cnt <= '0;
        end else if (sck_rise && ss_active && bit_cnt != CNT_MAX) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Output bit: present the top of the shift stage after select or clock fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miso_q <= 1'b0;
        end else if (ss_fall || (sck_fall && ss_active)) begin
            miso_q <= shift_q[FRAME_BITS-1];
        end
    end

    // Register write request: one-cycle pulse after a full write frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= do_write;
            if (do_write) begin
                wr_addr <= shift_q.addr;
                wr_data <= shift_q.data;
            end
        end
    end

    AST_MISO_HOLD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_rise && !ss_fall) |=> $stable(miso_q)); // R9

    AST_WR_FULL_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(bit_cnt == CNT_FULL)); // R6

    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R4

endmodule

// File: rtl/spi_cfg_bank.sv
// Module: spi_cfg_bank
// Bank of NUM_REGS 8-bit configuration registers at addresses 0..NUM_REGS-1.
// Only bits set in each register's write mask change on a write; all other
// bits stay at their reset value. Reads of unmapped addresses return zero.
module spi_cfg_bank
    import spi_chain_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] cfg_o
);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        localparam logic [DATA_W-1:0] RST_V = reg_reset_val(gi);
        localparam logic [DATA_W-1:0] MASK  = reg_wr_mask(gi);

        // Register gi: masked update on a matching write pulse
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[gi] <= RST_V;
            end else if (wr_en && wr_addr == ADDR_W'(gi)) begin
                regs[gi] <= (regs[gi] & ~MASK) | (wr_data & MASK);
            end
        end

        assign cfg_o[gi*DATA_W +: DATA_W] = regs[gi];

        AST_RESERVED_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
            (regs[gi] & ~MASK) == (RST_V & ~MASK)); // R7
    end

    // Read multiplexer: zero unless the address hits a mapped register
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_data = regs[i];
            end
        end
    end

endmodule

// File: rtl/spi_chain_slave.sv
// Module: spi_chain_slave (top)
// Chainable serial register slave: synchronizes the serial pins, runs the
// 16-bit echo shift stage and holds the configuration register bank.
// Assumes sck_i idles low and the system clock oversamples it by 4x or more.
module spi_chain_slave
    import spi_chain_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sck_i,
    input  logic                       ss_n_i,
    input  logic                       mosi_i,
    output logic                       miso_o,
    output logic                       miso_oe_o,
    output logic [NUM_REGS*DATA_W-1:0] cfg_o
);

    logic              sck_rise, sck_fall, ss_fall, ss_rise, ss_active, mosi_s;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_en;

    spi_pin_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_i     (sck_i),
        .ss_n_i    (ss_n_i),
        .mosi_i    (mosi_i),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .ss_fall   (ss_fall),
        .ss_rise   (ss_rise),
        .ss_active (ss_active),
        .mosi_s    (mosi_s)
    );

    spi_frame_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .ss_fall   (ss_fall),
        .ss_rise   (ss_rise),
        .ss_active (ss_active),
        .mosi_s    (mosi_s),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .miso_q    (miso_o),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    spi_cfg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg_o   (cfg_o)
    );

    // Pad enable: drive only inside a synchronized select window
    assign miso_oe_o = ss_active;

    AST_OE_TRACKS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe_o == !$past(ss_n_i, SYNC_STAGES)); // R3

endmodule

// File: tb/tb_spi_chain_slave.sv
// Directed bench: one task per scenario, each checking its own results
// against a bench-side model of the shift stage and register map.
module tb_spi_chain_slave;

    localparam int NREG = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sck = 1'b0;
    logic            ss_n = 1'b1;
    logic            mosi = 1'b0;
    logic            miso;
    logic            miso_oe;
    logic [NREG*8-1:0] cfg;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] model_sr;
    logic [7:0]  m_reg [NREG];
    logic [15:0] last_rx;

    always #2 clk = ~clk;   // 250 MHz

    spi_chain_slave #(.NUM_REGS(NREG)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_i     (sck),
        .ss_n_i    (ss_n),
        .mosi_i    (mosi),
        .miso_o    (miso),
        .miso_oe_o (miso_oe),
        .cfg_o     (cfg)
    );

    function automatic logic [7:0] bench_rst(input int i);
        case (i) 0: return 8'h00; 1: return 8'h5A; 2: return 8'h80; 3: return 8'h03; default: return 8'h00; endcase
    endfunction
    function automatic logic [7:0] bench_mask(input int i);
        case (i) 0: return 8'hFF; 1: return 8'hFF; 2: return 8'h0F; 3: return 8'hF3; default: return 8'h00; endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare all parallel register outputs with the model
    task automatic check_cfg(input string req, input string what);
        for (int i = 0; i < NREG; i++)
            check({24'h0, cfg[i*8 +: 8]}, {24'h0, m_reg[i]}, req, what);
    endtask

    // One select window of nbits serial bits taken from tx[nbits-1:0], MSB first
    task automatic run_frame(input logic [31:0] tx, input int nbits, input string what);
        logic [31:0] rx  = '0;
        logic [31:0] exp = '0;
        int          hold_err = 0;
        ss_n = 1'b0;
        wait_clk(8);
        check({31'h0, miso_oe}, 32'h1, "R3", {what, " enable inside window"});
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = tx[i];
            exp  = {exp[30:0], model_sr[15]};
            model_sr = {model_sr[14:0], tx[i]};
            wait_clk(4);
            rx = {rx[30:0], miso};
            sck = 1'b1;
            wait_clk(6);
            if (miso !== rx[0]) hold_err++;
            wait_clk(2);
            sck = 1'b0;
            wait_clk(4);
        end
        wait_clk(4);
        ss_n = 1'b1;
        wait_clk(10);
        check({31'h0, miso_oe}, 32'h0, "R3", {what, " enable after window"});
        check(hold_err, 0, "R9", {what, " output held across clock rise"});
        check(rx, exp, "R2", {what, " echo of previous frame"});
        last_rx = rx[15:0];
        if (nbits == 16) begin
            if (model_sr[15]) begin
                model_sr[7:0] = (model_sr[14:8] < NREG) ? m_reg[model_sr[14:8]] : 8'h00;
            end else if (model_sr[14:8] < NREG) begin
                int a = int'(model_sr[14:8]);
                m_reg[a] = (m_reg[a] & ~bench_mask(a)) | (model_sr[7:0] & bench_mask(a));
            end
        end
    endtask

    task automatic test_reset();
        for (int i = 0; i < NREG; i++) m_reg[i] = bench_rst(i);
        model_sr = '0;
        check_cfg("R8", "reset register values");
        check({31'h0, miso_oe}, 32'h0, "R8", "enable low after reset");
    endtask

    task automatic test_write_echo();
        run_frame(32'h01C3, 16, "write reg1");
        check({16'h0, last_rx}, 32'h0, "R8", "first frame output all zeros");
        check({24'h0, cfg[15:8]}, 32'hC3, "R4", "reg1 updated by write");
        run_frame(32'h00A5, 16, "write reg0");
        check({16'h0, last_rx}, 32'h01C3, "R2", "echo of write frame");
        check({24'h0, cfg[7:0]}, 32'hA5, "R1", "address and data field decode");
        check_cfg("R4", "bank after writes");
    endtask

    task automatic test_read();
        run_frame(32'h81FF, 16, "read reg1");
        run_frame(32'hFFFF, 16, "dummy after read reg1");
        check({16'h0, last_rx}, 32'h81C3, "R5", "read frame returns command, address and value");
        run_frame(32'h8055, 16, "read reg0 with odd padding");
        run_frame(32'hFFFF, 16, "dummy after read reg0");
        check({24'h0, last_rx[7:0]}, 32'hA5, "R5", "padding ignored, reg0 value returned");
        check_cfg("R5", "reads leave registers unchanged");
    endtask

    task automatic test_reserved();
        run_frame(32'h02FF, 16, "write ones reg2");
        check({24'h0, cfg[23:16]}, 32'h8F, "R7", "reg2 reserved bits keep reset");
        run_frame(32'h03FF, 16, "write ones reg3");
        check({24'h0, cfg[31:24]}, 32'hF3, "R7", "reg3 reserved bits keep reset");
        run_frame(32'h0300, 16, "write zeros reg3");
        check({24'h0, cfg[31:24]}, 32'h00, "R7", "reg3 writable bits cleared");
        run_frame(32'h82FF, 16, "read reg2");
        run_frame(32'hC0FF, 16, "read unmapped 0x40");
        check({24'h0, last_rx[7:0]}, 32'h8F, "R7", "reg2 readback with reserved bits");
        run_frame(32'hFFFF, 16, "dummy after unmapped read");
        check({16'h0, last_rx}, 32'hC000, "R7", "unmapped address reads zero");
    endtask

    task automatic test_discard();
        run_frame(32'h0011, 15, "short write frame");
        check_cfg("R6", "short frame writes nothing");
        run_frame(32'h00077, 17, "long write frame");
        check_cfg("R6", "long frame writes nothing");
        run_frame(32'h01FF, 15, "short read frame");
        run_frame(32'hFFFF, 16, "dummy after short read");
        check({16'h0, last_rx}, 32'h81FF, "R6", "short read frame loads no data");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        wait_clk(6);
        rst_n = 1'b1;
        wait_clk(4);
        test_reset();
        test_write_echo();
        test_read();
        test_reserved();
        test_discard();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule